// File: doc/BRIEF.md
# Interrupt-Capable GPIO Port Controller

This block controls a port of up to 32 general-purpose pins through a small word-addressed register bus. The bus has an address, a write strobe, write data and combinational read data. Software sets each pin to input or output and writes the values that output pins drive. It reads back the pin states, using synchronized samples for input pins and the driven value for output pins. The pads themselves are outside the block, which exposes output-value, output-enable and input vectors.

Each pin can raise an interrupt. Three per-pin bit registers choose the trigger: an edge-or-level select, a polarity, and a both-edges select. Trigger events latch into a raw status register whether or not the pin is enabled. The pending view is raw status masked by the per-pin enables, and all pending bits are ORed into a single interrupt line. Software acknowledges events by writing ones to a clear register. A read-only version word of 3 tells software that the both-edges trigger is present.

Top module: `gpio_irq_port`

## Requirements
- R1: After reset the interrupt enable register is all zeros, every direction bit is 1 (input), the output value register is 0, `pin_oe` is 0 and `irq` is 0.
- R2: The direction register at byte address 0x04 makes pin i an output when bit i is 0 and an input when it is 1. `pin_oe[i]` is the inverse of direction bit i, and `pin_out` carries the output value register written at 0x00.
- R3: A read of 0x00 returns, for input pins, `pin_in` after two clock edges of synchronization, and for output pins the last value written.
- R4: When the edge select bit (0x18) of a pin is 0, the pin is level-triggered. Polarity bit (0x1C) 1 means active high and 0 means active low. While the level stays active the status bit stays set, even after a clear.
- R5: When the edge select bit is 1 and the both-edges bit (0x24) is 0, polarity 1 triggers on a rising edge and polarity 0 on a falling edge. An edge sets the status bit on the third clock edge after the pin changes.
- R6: When both the edge select bit and the both-edges bit are 1, every transition of the pin sets its status bit.
- R7: Raw status (read at 0x0C) latches events regardless of the enables (0x08). Pending (read at 0x10) equals raw status AND enable, and `irq` is the OR of all pending bits.
- R8: A write to 0x14 clears each raw status bit written as 1 and leaves bits written as 0 unchanged. An event on a pin in the same cycle as the clear of that pin leaves the bit set.
- R9: Reading 0x20 returns 3. Writes to 0x0C, 0x10 and 0x20 have no effect, and any address outside the ten mapped words reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | ADDR_W | Byte address of the register access |
| bus_we | input | 1 | Write strobe, sampled on the rising clock edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| pin_in | input | NPINS | Pin levels from the pads, asynchronous |
| pin_out | output | NPINS | Values for the pins that are driven |
| pin_oe | output | NPINS | Output enable per pin, 1 drives |
| irq | output | 1 | Combined interrupt request |

## Verification
The embedded properties run on every cycle. They check that the enable register comes out of reset at zero and that a masked-off port never raises `irq`. They check that every trigger seen in one cycle shows up in raw status in the next, that a clear removes a bit only when no event competes with it, and that direction changes only through its own write. Only the bench scenarios show what each trigger mode does with a real pin waveform. These are level re-arming after a clear, rising versus falling versus both edges, the exact synchronizer latency, and the register map including the ignored writes and unmapped reads.

// File: rtl/gpio_irq_port.sv
module gpio_irq_port #(
  parameter int NPINS  = 32,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic [NPINS-1:0]  pin_in,
  output logic [NPINS-1:0]  pin_out,
  output logic [NPINS-1:0]  pin_oe,
  output logic              irq
);

  localparam logic [ADDR_W-1:0] A_VAL  = ADDR_W'(8'h00);
  localparam logic [ADDR_W-1:0] A_DIR  = ADDR_W'(8'h04);
  localparam logic [ADDR_W-1:0] A_IEN  = ADDR_W'(8'h08);
  localparam logic [ADDR_W-1:0] A_RAW  = ADDR_W'(8'h0C);
  localparam logic [ADDR_W-1:0] A_PEND = ADDR_W'(8'h10);
  localparam logic [ADDR_W-1:0] A_CLR  = ADDR_W'(8'h14);
  localparam logic [ADDR_W-1:0] A_EDGE = ADDR_W'(8'h18);
  localparam logic [ADDR_W-1:0] A_POL  = ADDR_W'(8'h1C);
  localparam logic [ADDR_W-1:0] A_VER  = ADDR_W'(8'h20);
  localparam logic [ADDR_W-1:0] A_BOTH = ADDR_W'(8'h24);
  localparam logic [31:0]       VERSION = 32'd3;

  logic [NPINS-1:0] out_q, dir_q, ien_q, raw_q;
  logic [NPINS-1:0] sel_edge_q, pol_q, both_q;
  logic [NPINS-1:0] sync1_q, sync2_q, prev_q;
  logic [NPINS-1:0] hit, clr_mask, pend, val_rd;
  logic [NPINS-1:0] lvl_hit, rise, fall, edge_hit;

  assign pin_out = out_q;
  assign pin_oe  = ~dir_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sync1_q <= '0;
      sync2_q <= '0;
      prev_q  <= '0;
    end else begin
      sync1_q <= pin_in;
      sync2_q <= sync1_q;
      prev_q  <= sync2_q;
    end
  end

  assign lvl_hit  = ~(pol_q ^ sync2_q);
  assign rise     = sync2_q & ~prev_q;
  assign fall     = ~sync2_q & prev_q;
  assign edge_hit = (both_q & (rise | fall)) |
                    (~both_q & ((pol_q & rise) | (~pol_q & fall)));
  assign hit      = (~sel_edge_q & lvl_hit) | (sel_edge_q & edge_hit);

  assign clr_mask = (bus_we && bus_addr == A_CLR) ? bus_wdata[NPINS-1:0] : '0;
  assign pend     = raw_q & ien_q;
  assign irq      = |pend;
  assign val_rd   = (dir_q & sync2_q) | (~dir_q & out_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_q      <= '0;
      dir_q      <= '1;
      ien_q      <= '0;
      sel_edge_q <= '0;
      pol_q      <= '0;
      both_q     <= '0;
      raw_q      <= '0;
    end else begin
      raw_q <= (raw_q & ~clr_mask) | hit;
      if (bus_we) begin
        case (bus_addr)
          A_VAL:  out_q      <= bus_wdata[NPINS-1:0];
          A_DIR:  dir_q      <= bus_wdata[NPINS-1:0];
          A_IEN:  ien_q      <= bus_wdata[NPINS-1:0];
          A_EDGE: sel_edge_q <= bus_wdata[NPINS-1:0];
          A_POL:  pol_q      <= bus_wdata[NPINS-1:0];
          A_BOTH: both_q     <= bus_wdata[NPINS-1:0];
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      A_VAL:  bus_rdata[NPINS-1:0] = val_rd;
      A_DIR:  bus_rdata[NPINS-1:0] = dir_q;
      A_IEN:  bus_rdata[NPINS-1:0] = ien_q;
      A_RAW:  bus_rdata[NPINS-1:0] = raw_q;
      A_PEND: bus_rdata[NPINS-1:0] = pend;
      A_EDGE: bus_rdata[NPINS-1:0] = sel_edge_q;
      A_POL:  bus_rdata[NPINS-1:0] = pol_q;
      A_BOTH: bus_rdata[NPINS-1:0] = both_q;
      A_VER:  bus_rdata = VERSION;
      default: ;
    endcase
  end

  a_r1_ien_zero_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!rst_n) |-> (ien_q == '0));

  a_r7_masked_no_irq: assert property (@(posedge clk) disable iff (!rst_n)
    (ien_q == '0) |-> !irq);

  a_r8_event_latches: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> ((raw_q & $past(hit)) == $past(hit)));

  a_r8_clear_removes: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> ((raw_q & $past(clr_mask & ~hit)) == '0));

  a_r2_dir_only_by_write: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !$past(bus_we && bus_addr == A_DIR)) |-> (dir_q == $past(dir_q)));

endmodule

// File: tb/gpio_irq_port_tb.sv
module gpio_irq_port_tb_top;
  localparam int NP = 32;
  localparam int NV = 22;

  logic          clk = 0;
  logic          rst_n = 0;
  logic [7:0]    bus_addr = '0;
  logic          bus_we = 0;
  logic [31:0]   bus_wdata = '0;
  logic [31:0]   bus_rdata;
  logic [NP-1:0] pin_in = '0;
  logic [NP-1:0] pin_out, pin_oe;
  logic          irq;
  int            n_chk = 0, n_fail = 0;
  bit            done = 0;

  always #5 clk = ~clk;

  gpio_irq_port #(.NPINS(NP), .ADDR_W(8)) dut_i (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
    .pin_out(pin_out), .pin_oe(pin_oe), .irq(irq)
  );

  // {addr, we, wdata, expected read}
  localparam logic [72:0] VEC [NV] = '{
    {8'h04, 1'b1, 32'h0000_00FF, 32'h0},
    {8'h04, 1'b0, 32'h0,         32'h0000_00FF},
    {8'h00, 1'b1, 32'hA5A5_A5A5, 32'h0},
    {8'h00, 1'b0, 32'h0,         32'hA5A5_A500},
    {8'h08, 1'b1, 32'h1234_0000, 32'h0},
    {8'h08, 1'b0, 32'h0,         32'h1234_0000},
    {8'h10, 1'b0, 32'h0,         32'h1234_0000},
    {8'h08, 1'b1, 32'h0,         32'h0},
    {8'h10, 1'b0, 32'h0,         32'h0},
    {8'h20, 1'b1, 32'hFFFF_FFFF, 32'h0},
    {8'h20, 1'b0, 32'h0,         32'h3},
    {8'h0C, 1'b1, 32'h0,         32'h0},
    {8'h10, 1'b1, 32'h0,         32'h0},
    {8'h0C, 1'b0, 32'h0,         32'hFFFF_FFFF},
    {8'h28, 1'b1, 32'hDEAD_BEEF, 32'h0},
    {8'h28, 1'b0, 32'h0,         32'h0},
    {8'h3C, 1'b0, 32'h0,         32'h0},
    {8'h08, 1'b0, 32'h0,         32'h0},
    {8'h18, 1'b1, 32'hFFFF_0000, 32'h0},
    {8'h18, 1'b0, 32'h0,         32'hFFFF_0000},
    {8'h24, 1'b1, 32'h0F0F_0F0F, 32'h0},
    {8'h24, 1'b0, 32'h0,         32'h0F0F_0F0F}
  };

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_we = 1; bus_wdata = d;
    @(negedge clk);
    bus_we = 0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic wait3();
    repeat (3) @(negedge clk);
  endtask

  initial begin
    logic [31:0] r;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    rd(8'h08, r); chk("R1 ien", r, 32'h0);
    rd(8'h04, r); chk("R1 dir", r, 32'hFFFF_FFFF);
    chk("R1 pin_oe", pin_oe, 32'h0);
    chk("R1 pin_out", pin_out, 32'h0);
    chk("R1 irq", {31'b0, irq}, 32'h0);

    // register-map walk: R2 R3 R7 R9
    for (int i = 0; i < NV; i++) begin
      if (VEC[i][64]) wr(VEC[i][72:65], VEC[i][63:32]);
      else begin
        @(negedge clk);
        rd(VEC[i][72:65], r);
        chk($sformatf("R9 map vector %0d", i), r, VEC[i][31:0]);
      end
    end

    // R2 pad control
    chk("R2 pin_oe", pin_oe, 32'hFFFF_FF00);
    chk("R2 pin_out", pin_out, 32'hA5A5_A5A5);

    // R3 synchronizer latency
    wr(8'h04, 32'hFFFF_FFFF);
    @(negedge clk); pin_in = 32'h0000_0F0F;
    @(negedge clk); rd(8'h00, r); chk("R3 one edge", r, 32'h0);
    @(negedge clk); rd(8'h00, r); chk("R3 two edges", r, 32'h0000_0F0F);
    pin_in = '0;
    wait3();

    // trigger configuration: pin0 level high, pin1 level low,
    // pin2 rising, pin3 falling, pin4 both, pin5 rising
    wr(8'h18, 32'h0000_003C);
    wr(8'h24, 32'h0000_0010);
    wr(8'h1C, 32'h0000_0025);
    @(negedge clk);
    wr(8'h14, 32'h0000_003F);
    @(negedge clk);
    rd(8'h0C, r); chk("R4 after clear", r & 32'h3F, 32'h0000_0002);

    // R4 level high
    pin_in[0] = 1; wait3();
    rd(8'h0C, r); chk("R4 level high set", r & 32'h1, 32'h1);
    wr(8'h14, 32'h1);
    rd(8'h0C, r); chk("R4 level re-set after clear", r & 32'h1, 32'h1);
    pin_in[0] = 0; wait3();
    wr(8'h14, 32'h1);
    rd(8'h0C, r); chk("R4 level inactive clears", r & 32'h1, 32'h0);

    // R5 single edges
    pin_in[3:2] = 2'b11; wait3();
    rd(8'h0C, r); chk("R5 rise", r & 32'hC, 32'h4);
    wr(8'h14, 32'hC);
    rd(8'h0C, r); chk("R5 edge clears", r & 32'hC, 32'h0);
    pin_in[3:2] = 2'b00; wait3();
    rd(8'h0C, r); chk("R5 fall", r & 32'hC, 32'h8);
    wr(8'h14, 32'hC);

    // R6 both edges
    pin_in[4] = 1; wait3();
    rd(8'h0C, r); chk("R6 rising", r & 32'h10, 32'h10);
    wr(8'h14, 32'h10);
    rd(8'h0C, r); chk("R6 cleared", r & 32'h10, 32'h0);
    pin_in[4] = 0; wait3();
    rd(8'h0C, r); chk("R6 falling", r & 32'h10, 32'h10);
    wr(8'h14, 32'h10);

    // R7 pending and irq
    wr(8'h08, 32'h10);
    chk("R7 irq idle", {31'b0, irq}, 32'h0);
    pin_in[4] = 1; wait3();
    chk("R7 irq raised", {31'b0, irq}, 32'h1);
    rd(8'h10, r); chk("R7 pending masked", r, 32'h10);
    rd(8'h0C, r); chk("R7 raw ignores enable", r & 32'h2, 32'h2);
    wr(8'h14, 32'h10);
    chk("R7 irq dropped", {31'b0, irq}, 32'h0);
    wr(8'h08, 32'h0);

    // R8 clear collides with edge event; zero bits untouched
    pin_in[2] = 1; wait3();
    @(negedge clk); pin_in[5] = 1;
    @(negedge clk);
    wr(8'h14, 32'h20);
    rd(8'h0C, r); chk("R8 event wins over clear", r & 32'h24, 32'h24);
    wr(8'h14, 32'h24);
    rd(8'h0C, r); chk("R8 clear both", r & 32'h24, 32'h0);

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule